// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block decides when the next thread block waiting for a streaming multiprocessor may start. The head of an in-order launch queue presents one request, made up of a thread count, the registers each thread needs and the bytes of shared memory the block needs. The block grants the request in the same cycle only if three things hold at once: a residency slot is free, the register file has room for every warp the block will occupy, and enough shared memory is free. Warps are 32 threads wide, so a block of T threads occupies ceil(T/32) warps. It reserves warps × 32 × registers-per-thread registers.

A granted block holds its slot, registers and shared memory until it signals completion. It signals completion with a pulse on the completion bit of its slot. That pulse returns all three resources together. Resources freed by a completion in a given cycle already count toward the admission decision of that same cycle. A head request that does not fit keeps the grant low, and the queue behind it waits. The free-slot, free-register and free-shared-memory counters are always visible.

Top module: `blk_admit_ctl`

## Requirements
- R1: After reset, free_slots equals NSLOT, free_regs equals REG_FILE, free_smem equals SMEM_BYTES, and launch_valid is low while req_valid is low.
- R2: A granted block reserves ceil(req_threads/WARP) × WARP × req_regs registers and req_smem bytes. The register count shown on free_regs drops by that amount on the clock edge after the grant.
- R3: launch_valid is asserted only when fewer than NSLOT blocks remain resident after this cycle's completions are taken into account. With all slots held and no completion, a request is not granted.
- R4: launch_valid is asserted only when the register demand of R2 does not exceed free_regs plus the registers released in the same cycle. A demand equal to that sum is granted.
- R5: launch_valid is asserted only when req_smem does not exceed free_smem plus the bytes released in the same cycle. A demand equal to that sum is granted.
- R6: launch_slot is the lowest-numbered slot that is either empty or being released in the current cycle.
- R7: A pulse on blk_done[s] for a resident slot s returns that block's slot, registers and shared memory on the next clock edge.
- R8: A pulse on blk_done[s] for a slot that holds no block has no effect on any counter.
- R9: A completion and a grant in the same cycle both take effect. The freed resources are counted before the fit check, and the freed slot may be reused at once.
- R10: launch_valid is never high while req_valid is low. The grant is a pure function of the current request and state, so a held, non-fitting request stays ungranted until resources free up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head-of-queue request present |
| req_threads | input | TW | Threads in the requested block (1..MAX_THREADS) |
| req_regs | input | RW | Registers needed per thread |
| req_smem | input | SW | Shared memory bytes needed by the block |
| blk_done | input | NSLOT | One completion pulse bit per slot |
| launch_valid | output | 1 | Request admitted this cycle |
| launch_slot | output | SLW | Slot given to the admitted block |
| free_slots | output | CW | Number of empty slots |
| free_regs | output | RFW | Unreserved registers |
| free_smem | output | SW | Unreserved shared memory bytes |

## Verification
The assertions rely on these input conditions:
- A request carries 1 to MAX_THREADS threads.
- A request's register and shared-memory demands never exceed the full capacity. A larger demand would stall the queue forever rather than break any counter.
- Completion pulses may arrive on any slot, resident or not.

The stimulus keeps every request within capacity. Registers per thread are bounded so that even a full-size block fits the register file exactly. The bench holds a request unchanged until the grant is seen, as an in-order queue head would. The stimulus mixes completions on empty slots into both the directed and the pseudo-random phases, so the conservation checks are exercised with those ignored pulses present.

// File: rtl/blk_admit_pkg.sv
package blk_admit_pkg;

   // Integer ceiling division used for elaboration-time sizing.
   function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
      return (num + den - 1) / den;
   endfunction

   // True when the argument is a nonzero power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Larger of two integers, for sizing comparators.
   function automatic int unsigned imax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/blk_demand_calc.sv
// Converts a block request into its warp count and register reservation.
module blk_demand_calc
   import blk_admit_pkg::*;
#(
   parameter int unsigned TW   = 11,
   parameter int unsigned RW   = 8,
   parameter int unsigned WARP = 32,
   parameter int unsigned WW   = 6,
   parameter int unsigned DW   = 20
) (
   input  logic [TW-1:0] threads,
   input  logic [RW-1:0] regs_per_thread,
   output logic [WW-1:0] warps,
   output logic [DW-1:0] reg_demand
);

   localparam int unsigned LG = (WARP > 1) ? $clog2(WARP) : 1;

   logic [TW:0] padded;

   assign padded = {1'b0, threads} + (TW+1)'(WARP - 1);

   generate
      if (is_pow2(WARP)) begin : g_shift
         logic [TW:0] shifted;
         assign shifted = padded >> LG;
         assign warps   = WW'(shifted);
      end else begin : g_divide
         logic [TW:0] quot;
         assign quot  = padded / (TW+1)'(WARP);
         assign warps = WW'(quot);
      end
   endgenerate

   assign reg_demand = DW'(warps) * DW'(WARP) * DW'(regs_per_thread);

endmodule

// File: rtl/blk_slot_pick.sv
// Finds the lowest-numbered available slot.
module blk_slot_pick #(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned SLW   = 3
) (
   input  logic [NSLOT-1:0] avail,
   output logic             any,
   output logic [SLW-1:0]   idx
);

   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (avail[i]) begin
            any = 1'b1;
            idx = SLW'(i);
         end
      end
   end

   // Every slot index should be reachable.
   initial begin
      if ((1 << SLW) < NSLOT) $error("slot index too narrow");
   end

endmodule

// File: rtl/blk_slot_table.sv
// Per-slot record of what each resident block holds.
module blk_slot_table #(
   parameter int unsigned NSLOT = 8,
   parameter int unsigned SLW   = 3,
   parameter int unsigned RFW   = 17,
   parameter int unsigned SW    = 16,
   parameter int unsigned CW    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 alloc,
   input  logic [SLW-1:0]       alloc_slot,
   input  logic [RFW-1:0]       alloc_regs,
   input  logic [SW-1:0]        alloc_smem,
   input  logic [NSLOT-1:0]     done_in,
   output logic [NSLOT-1:0]     resident,
   output logic [NSLOT-1:0]     rel_mask,
   output logic [RFW-1:0]       rel_regs,
   output logic [SW-1:0]        rel_smem,
   output logic [CW-1:0]        rel_cnt,
   output logic [RFW+CW-1:0]    held_regs,
   output logic [SW+CW-1:0]     held_smem
);

   logic [RFW-1:0] slot_regs [NSLOT];
   logic [SW-1:0]  slot_smem [NSLOT];

   assign rel_mask = done_in & resident;

   generate
      for (genvar s = 0; s < NSLOT; s++) begin : g_slot
         logic take;
         assign take = alloc && (alloc_slot == SLW'(s));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               resident[s]  <= 1'b0;
               slot_regs[s] <= '0;
               slot_smem[s] <= '0;
            end else if (take) begin
               resident[s]  <= 1'b1;
               slot_regs[s] <= alloc_regs;
               slot_smem[s] <= alloc_smem;
            end else if (rel_mask[s]) begin
               resident[s]  <= 1'b0;
               slot_regs[s] <= '0;
               slot_smem[s] <= '0;
            end
         end

         // A pulse on an empty slot must not make it resident.
         p_idle_done_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (done_in[s] && !resident[s] && !take) |=> !resident[s]);

         // A released slot is empty on the next edge unless it was reallocated.
         p_release_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_mask[s] && !take) |=> !resident[s]);
      end
   endgenerate

   always_comb begin
      rel_regs  = '0;
      rel_smem  = '0;
      rel_cnt   = '0;
      held_regs = '0;
      held_smem = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (rel_mask[s]) begin
            rel_regs = rel_regs + slot_regs[s];
            rel_smem = rel_smem + slot_smem[s];
            rel_cnt  = rel_cnt + CW'(1);
         end
         if (resident[s]) begin
            held_regs = held_regs + (RFW+CW)'(slot_regs[s]);
            held_smem = held_smem + (SW+CW)'(slot_smem[s]);
         end
      end
   end

   // Allocation lands only on an empty slot or one being freed now.
   p_alloc_free_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alloc |-> (!resident[alloc_slot] || rel_mask[alloc_slot]));

endmodule

// File: rtl/blk_admit_ctl.sv
// In-order thread block admission into one multiprocessor.
module blk_admit_ctl
   import blk_admit_pkg::*;
#(
   parameter int unsigned NSLOT       = 8,
   parameter int unsigned MAX_THREADS = 1024,
   parameter int unsigned WARP        = 32,
   parameter int unsigned REGS_MAX    = 255,
   parameter int unsigned REG_FILE    = 65536,
   parameter int unsigned SMEM_BYTES  = 49152,
   localparam int unsigned TW   = $clog2(MAX_THREADS + 1),
   localparam int unsigned RW   = $clog2(REGS_MAX + 1),
   localparam int unsigned SW   = $clog2(SMEM_BYTES + 1),
   localparam int unsigned RFW  = $clog2(REG_FILE + 1),
   localparam int unsigned SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
   localparam int unsigned CW   = $clog2(NSLOT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [TW-1:0]    req_threads,
   input  logic [RW-1:0]    req_regs,
   input  logic [SW-1:0]    req_smem,
   input  logic [NSLOT-1:0] blk_done,
   output logic             launch_valid,
   output logic [SLW-1:0]   launch_slot,
   output logic [CW-1:0]    free_slots,
   output logic [RFW-1:0]   free_regs,
   output logic [SW-1:0]    free_smem
);

   localparam int unsigned MAXW = ceil_div(MAX_THREADS, WARP);
   localparam int unsigned WW   = $clog2(MAXW + 1);
   localparam int unsigned LGW  = (WARP > 1) ? $clog2(WARP) : 1;
   localparam int unsigned DW   = WW + LGW + RW + 1;
   localparam int unsigned CMPW = imax(DW, RFW + 1);

   // Elaboration-time parameter checks.
   generate
      if (NSLOT < 2)          begin : g_bad_nslot $error("NSLOT must be at least 2"); end
      if (WARP < 1)           begin : g_bad_warp  $error("WARP must be nonzero"); end
      if (MAX_THREADS < WARP) begin : g_bad_thr   $error("MAX_THREADS below one warp"); end
      if (REG_FILE < WARP)    begin : g_bad_rf    $error("register file below one warp"); end
      if (SMEM_BYTES < 1)     begin : g_bad_smem  $error("SMEM_BYTES must be nonzero"); end
   endgenerate

   logic [WW-1:0]          warps;
   logic [DW-1:0]          reg_demand;
   logic [NSLOT-1:0]       resident;
   logic [NSLOT-1:0]       rel_mask;
   logic [RFW-1:0]         rel_regs;
   logic [SW-1:0]          rel_smem;
   logic [CW-1:0]          rel_cnt;
   logic [RFW+CW-1:0]      held_regs;
   logic [SW+CW-1:0]       held_smem;
   logic                   slot_any;
   logic [SLW-1:0]         slot_idx;
   logic [CMPW-1:0]        avail_regs;
   logic [CMPW-1:0]        demand_ext;
   logic [SW:0]            avail_smem;
   logic                   regs_fit;
   logic                   smem_fit;
   logic                   grant;
   logic [CMPW-1:0]        regs_after;
   logic [SW:0]            smem_after;

   blk_demand_calc #(
      .TW(TW), .RW(RW), .WARP(WARP), .WW(WW), .DW(DW)
   ) u_demand (
      .threads         (req_threads),
      .regs_per_thread (req_regs),
      .warps           (warps),
      .reg_demand      (reg_demand)
   );

   blk_slot_table #(
      .NSLOT(NSLOT), .SLW(SLW), .RFW(RFW), .SW(SW), .CW(CW)
   ) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc      (grant),
      .alloc_slot (slot_idx),
      .alloc_regs (RFW'(reg_demand)),
      .alloc_smem (req_smem),
      .done_in    (blk_done),
      .resident   (resident),
      .rel_mask   (rel_mask),
      .rel_regs   (rel_regs),
      .rel_smem   (rel_smem),
      .rel_cnt    (rel_cnt),
      .held_regs  (held_regs),
      .held_smem  (held_smem)
   );

   blk_slot_pick #(
      .NSLOT(NSLOT), .SLW(SLW)
   ) u_pick (
      .avail (~resident | rel_mask),
      .any   (slot_any),
      .idx   (slot_idx)
   );

   // Freed resources count before the fit check.
   assign avail_regs = CMPW'(free_regs) + CMPW'(rel_regs);
   assign demand_ext = CMPW'(reg_demand);
   assign avail_smem = {1'b0, free_smem} + {1'b0, rel_smem};
   assign regs_fit   = (demand_ext <= avail_regs);
   assign smem_fit   = ({1'b0, req_smem} <= avail_smem);
   assign grant      = req_valid && slot_any && regs_fit && smem_fit;

   assign regs_after = avail_regs - (grant ? demand_ext : '0);
   assign smem_after = avail_smem - (grant ? {1'b0, req_smem} : '0);

   assign launch_valid = grant;
   assign launch_slot  = slot_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_slots <= CW'(NSLOT);
         free_regs  <= RFW'(REG_FILE);
         free_smem  <= SW'(SMEM_BYTES);
      end else begin
         free_slots <= free_slots + rel_cnt - CW'(grant);
         free_regs  <= RFW'(regs_after);
         free_smem  <= SW'(smem_after);
      end
   end

   // Counters and per-slot holdings always add up to the capacity.
   p_slots_conserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(free_slots) + 32'($countones(resident))) == NSLOT);

   p_regs_conserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((RFW+CW+1)'(free_regs) + (RFW+CW+1)'(held_regs)) == (RFW+CW+1)'(REG_FILE));

   p_smem_conserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((SW+CW+1)'(free_smem) + (SW+CW+1)'(held_smem)) == (SW+CW+1)'(SMEM_BYTES));

   p_regs_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(free_regs) <= REG_FILE);

   p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      launch_valid |-> req_valid);

   // A grant lowers the register counter by the block's full reservation.
   p_grant_reserves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_valid && rel_mask == '0) |=>
         (CMPW'(free_regs) + $past(demand_ext)) == CMPW'($past(free_regs)));

endmodule

// File: tb/blk_admit_ctl_bench.sv
module blk_admit_ctl_bench;

   localparam int NS   = 4;
   localparam int MT   = 256;
   localparam int WP   = 32;
   localparam int RMX  = 63;
   localparam int RF   = 4096;
   localparam int SM   = 1024;
   localparam int TW   = $clog2(MT + 1);
   localparam int RW   = $clog2(RMX + 1);
   localparam int SW   = $clog2(SM + 1);
   localparam int RFW  = $clog2(RF + 1);
   localparam int SLW  = $clog2(NS);
   localparam int CW   = $clog2(NS + 1);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic [TW-1:0]  req_threads = '0;
   logic [RW-1:0]  req_regs = '0;
   logic [SW-1:0]  req_smem = '0;
   logic [NS-1:0]  blk_done = '0;
   logic           launch_valid;
   logic [SLW-1:0] launch_slot;
   logic [CW-1:0]  free_slots;
   logic [RFW-1:0] free_regs;
   logic [SW-1:0]  free_smem;

   always #4 clk = ~clk;

   blk_admit_ctl #(
      .NSLOT(NS), .MAX_THREADS(MT), .WARP(WP), .REGS_MAX(RMX),
      .REG_FILE(RF), .SMEM_BYTES(SM)
   ) u_blk_admit_ctl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_threads(req_threads),
      .req_regs(req_regs), .req_smem(req_smem), .blk_done(blk_done),
      .launch_valid(launch_valid), .launch_slot(launch_slot),
      .free_slots(free_slots), .free_regs(free_regs), .free_smem(free_smem)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // Reference state derived from the requirements.
   bit m_res  [NS];
   int m_regs [NS];
   int m_smem [NS];
   int m_free_regs = RF;
   int m_free_smem = SM;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int demand(input int th, input int rg);
      return ((th + WP - 1) / WP) * WP * rg;
   endfunction

   // One cycle: drive, check grant, clock, check counters.
   task automatic step(input bit v, input int th, input int rg, input int sm,
                       input logic [NS-1:0] dn, input string tag, output bit granted);
      int rel_r, rel_s, slot, avail_r, avail_s, nfree;
      bit eg;
      @(negedge clk);
      req_valid   = v;
      req_threads = TW'(th);
      req_regs    = RW'(rg);
      req_smem    = SW'(sm);
      blk_done    = dn;
      #1;
      rel_r = 0; rel_s = 0; slot = -1; nfree = 0;
      for (int s = 0; s < NS; s++) begin
         if (dn[s] && m_res[s]) begin
            rel_r += m_regs[s];
            rel_s += m_smem[s];
         end
         if (!m_res[s] || dn[s]) begin
            nfree++;
            if (slot < 0) slot = s;
         end
      end
      avail_r = m_free_regs + rel_r;
      avail_s = m_free_smem + rel_s;
      eg = v && (nfree > 0) && (demand(th, rg) <= avail_r) && (sm <= avail_s);
      chk(tag, "launch_valid", launch_valid, eg);
      if (eg) chk(tag, "launch_slot", launch_slot, slot);
      @(posedge clk);
      for (int s = 0; s < NS; s++) begin
         if (dn[s] && m_res[s]) begin
            m_res[s] = 0; m_regs[s] = 0; m_smem[s] = 0;
         end
      end
      m_free_regs = avail_r;
      m_free_smem = avail_s;
      if (eg) begin
         m_res[slot]  = 1;
         m_regs[slot] = demand(th, rg);
         m_smem[slot] = sm;
         m_free_regs -= demand(th, rg);
         m_free_smem -= sm;
      end
      #2;
      begin
         int cnt;
         cnt = 0;
         for (int s = 0; s < NS; s++) if (!m_res[s]) cnt++;
         chk(tag, "free_slots", free_slots, cnt);
      end
      chk(tag, "free_regs", free_regs, m_free_regs);
      chk(tag, "free_smem", free_smem, m_free_smem);
      granted = eg;
   endtask

   function automatic logic [NS-1:0] res_mask();
      logic [NS-1:0] m;
      for (int s = 0; s < NS; s++) m[s] = m_res[s];
      return m;
   endfunction

   initial begin : watchdog
      int cyc;
      cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin : stim
      bit g;
      logic [15:0] lfsr;
      int th, rg, sm;
      for (int s = 0; s < NS; s++) begin m_res[s] = 0; m_regs[s] = 0; m_smem[s] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "launch_valid", launch_valid, 0);
      chk("R1", "free_slots", free_slots, NS);
      chk("R1", "free_regs", free_regs, RF);
      chk("R1", "free_smem", free_smem, SM);

      // R2 sweep of every thread count, with an exact-fit case at 256 threads x 16 regs
      for (int t = 1; t <= MT; t++) begin
         step(1, t, ((t - 1) % 16) + 1, (t * 4) % (SM + 1), '0, "R2", g);
         chk("R2", "granted", g, 1);
         step(0, 0, 0, 0, 4'b0001, "R7", g);
      end

      // R6 lowest-slot order, then R3 slot exhaustion
      for (int k = 0; k < NS; k++) step(1, 32, 1, 1, '0, "R6", g);
      step(1, 32, 1, 1, '0, "R3", g);
      chk("R3", "granted with full slots", g, 0);
      // R9 completion on slot 2 with a waiting request
      step(1, 32, 1, 1, 4'b0100, "R9", g);
      chk("R9", "granted on freed slot", g, 1);
      step(0, 0, 0, 0, 4'b1111, "R7", g);
      // R8 pulses on empty slots
      step(0, 0, 0, 0, 4'b1111, "R8", g);
      step(0, 0, 0, 0, 4'b0010, "R8", g);

      // R4 register exhaustion while slots remain
      step(1, 256, 12, 0, '0, "R4", g);
      step(1, 64, 17, 0, '0, "R4", g);
      chk("R4", "granted beyond free regs", g, 0);
      step(1, 64, 16, 0, '0, "R4", g);
      chk("R4", "granted at exact free regs", g, 1);
      step(1, 64, 17, 0, 4'b0001, "R9", g);
      chk("R9", "granted with same-cycle release", g, 1);
      step(0, 0, 0, 0, 4'b1111, "R7", g);

      // R5 shared memory exhaustion
      step(1, 32, 1, 1000, '0, "R5", g);
      step(1, 32, 1, 25, '0, "R5", g);
      chk("R5", "granted beyond free smem", g, 0);
      step(1, 32, 1, 24, '0, "R5", g);
      chk("R5", "granted at exact free smem", g, 1);
      step(0, 0, 0, 0, 4'b1111, "R7", g);

      // R10 no grant without a request
      step(0, 32, 1, 1, '0, "R10", g);

      // Mixed pseudo-random traffic with held head requests
      lfsr = 16'hACE1;
      th = 1; rg = 1; sm = 0;
      g = 1;
      for (int i = 0; i < 4000; i++) begin
         logic [NS-1:0] dn;
         if (g) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            th = (lfsr % MT) + 1;
            rg = ((lfsr >> 8) % 16) + 1;
            sm = (lfsr * 7) % 600;
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         dn = NS'(lfsr[3:0]) & (lfsr[4] ? res_mask() : NS'(lfsr[7:5]));
         step(lfsr[8] | lfsr[9], th, rg, sm, dn, "R9", g);
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule